// File: doc/BRIEF.md
# Field-Window Nibble Arithmetic Unit

This block performs one arithmetic or data-movement operation on a pair of 16-nibble registers. Only a contiguous span of nibbles, the field window, takes part. A 4-bit field code picks the span, and two of the codes also depend on a pointer input. The unit works one nibble per clock, starting at the low end of the span and moving to the high end. A carry or borrow passes from each nibble to the next. A mode bit chooses whether each digit is handled as plain hexadecimal or as a decimal (BCD) digit.

A command enters through a valid/ready handshake. The unit captures both operands and all control fields when `cmd_valid` and `cmd_ready` are both high on a clock edge. It then drops `cmd_ready` until the operation has finished, so the launching side simply holds its request until ready comes back; while ready is low, any command offered is not accepted and has no effect. When the last nibble of the window has been written, `done` pulses for one cycle. The two result registers and the carry flag can be read in that cycle. They keep their values until the next command is accepted. The unit has no instruction decoding and no register file of its own.

Top module: `fsel_nib_alu`

## Requirements
- R1: `cmd_ready` is high whenever no operation is in progress. A command is captured on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the edge that raises `done`.
- R2: With window [lo,hi], `done` goes high exactly hi-lo+1 clock edges after the accepting edge, and it stays high for a single cycle.
- R3: The window is chosen by `cmd_field` (with p = `cmd_p`). The codes are: 0 gives [p,p]; 1 gives [0,p]; 2 gives [2,2]; 3 gives [0,2]; 4 gives [15,15]; 5 gives [3,14]; 6 gives [0,1]; 7 gives [0,15]; 15 gives [0,4]. Codes 8 to 14 give [0,0].
- R4: Every nibble of `res_a` and `res_b` outside the window equals the matching nibble of `opa` and `opb`, respectively.
- R5: The operation codes in `cmd_op` are ADD=0 (a+b), SUB=1 (a-b), INC=2 (a+1) and DEC=3 (a-1), each written into `res_a`, and `res_b` keeps `opb`. In hex mode (`cmd_dec`=0), each nibble is the raw sum or difference taken modulo 16. The outgoing carry is 1 exactly when that raw value is below 0 or above 15.
- R6: In decimal mode, a raw per-nibble sum s (0 to 31) produces the digit s mod 10, with carry 1 when s >= 10. Digits that are not valid BCD are still reduced this way.
- R7: In decimal mode, a raw per-nibble difference s produces one of three results. If s < 0, the digit is (s+10) mod 16 and the borrow is 1. If 0 <= s <= 9, the digit is s and the borrow is 0. If 10 <= s <= 15, the digit is s-10 and the borrow is 0.
- R8: ADD and SUB start the chain at the low end of the window with carry 0. INC and DEC start with carry 1 and use 0 as the second operand. The carry leaving the high end is stored in `carry`.
- R9: CLR=4 sets the window of `res_a` to 0. COPY=5 puts `opb`'s window into `res_a`. EXCH=6 swaps the windows of the two operands. PASS=7 returns both operands unchanged. None of these four changes `carry`.
- R10: After reset, `carry`, `done`, `res_a` and `res_b` are 0. `carry` keeps its value between operations.
- R11: A command offered while an operation is in progress is not accepted, and it does not change the result of the operation already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The unit is idle and can accept a command |
| cmd_op | input | 3 | Operation code (see R5, R9) |
| cmd_field | input | 4 | Field window code (see R3) |
| cmd_p | input | 4 | Pointer used by field codes 0 and 1 |
| cmd_dec | input | 1 | 1 selects decimal digit arithmetic, 0 selects hexadecimal |
| opa | input | 64 | First operand; nibble n is bits 4n+3:4n |
| opb | input | 64 | Second operand |
| res_a | output | 64 | Destination register result |
| res_b | output | 64 | Second register result; differs from `opb` only for exchange |
| carry | output | 1 | Carry/borrow flag |
| done | output | 1 | One-cycle pulse when the results are complete |

## Verification
The bench sweeps all 256 digit pairs for add and subtract in both modes. This finds a decimal adjust that fails on non-BCD sums such as 15+15, which must give 0 with a carry, or a borrow rule that mishandles differences of 10 to 15. A design with those faults would return wrong digits or a wrong carry. Every field code is run with several pointer values, against every operation and with pseudo-random data. This catches a window that is off by one nibble: such a design would change a neighbouring nibble or give the wrong latency. It also catches a copy, clear or exchange that disturbs the carry. Directed cases cover 9+9 in decimal, decrementing 0 in decimal and incrementing F in hex. Another directed case offers a second command during a long operation, which a design that failed to hold off new commands would start executing.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_CLR  = 3'd4,
    OP_COPY = 3'd5,
    OP_EXCH = 3'd6,
    OP_PASS = 3'd7
  } fsa_op_e;

  function automatic logic op_is_arith(fsa_op_e o);
    return (o == OP_ADD) || (o == OP_SUB) || (o == OP_INC) || (o == OP_DEC);
  endfunction

  function automatic logic op_is_sub(fsa_op_e o);
    return (o == OP_SUB) || (o == OP_DEC);
  endfunction

  function automatic logic op_is_unary(fsa_op_e o);
    return (o == OP_INC) || (o == OP_DEC);
  endfunction
endpackage

// File: rtl/fsa_window.sv
module fsa_window #(
  parameter int NUM_NIB = 16,
  localparam int IDX_W = $clog2(NUM_NIB)
) (
  input  logic [3:0]       code,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] lo,
  output logic [IDX_W-1:0] hi
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_NIB - 1);

  always_comb begin
    lo = '0;
    hi = '0;
    case (code)
      4'd0:  begin lo = ptr;          hi = ptr;            end
      4'd1:  begin lo = '0;           hi = ptr;            end
      4'd2:  begin lo = IDX_W'(2);    hi = IDX_W'(2);      end
      4'd3:  begin lo = '0;           hi = IDX_W'(2);      end
      4'd4:  begin lo = LAST;         hi = LAST;           end
      4'd5:  begin lo = IDX_W'(3);    hi = LAST - 1'b1;    end
      4'd6:  begin lo = '0;           hi = IDX_W'(1);      end
      4'd7:  begin lo = '0;           hi = LAST;           end
      4'd15: begin lo = '0;           hi = IDX_W'(4);      end
      default: begin lo = '0;         hi = '0;             end
    endcase
  end
endmodule

// File: rtl/fsa_digit.sv
module fsa_digit (
  input  logic [3:0] x,
  input  logic [3:0] y,
  input  logic       cin,
  input  logic       sub,
  input  logic       dec,
  output logic [3:0] d,
  output logic       cout
);
  int s;

  always_comb begin
    if (sub) s = int'(x) - int'(y) - int'(cin);
    else     s = int'(x) + int'(y) + int'(cin);
    if (!dec) begin
      d    = 4'(s);
      cout = (s < 0) || (s > 15);
    end else if (!sub) begin
      cout = (s >= 10);
      if      (s >= 30) d = 4'(s - 30);
      else if (s >= 20) d = 4'(s - 20);
      else if (s >= 10) d = 4'(s - 10);
      else              d = 4'(s);
    end else begin
      cout = (s < 0);
      if      (s < 0)   d = 4'(s + 10);
      else if (s >= 10) d = 4'(s - 10);
      else              d = 4'(s);
    end
  end
endmodule

// File: rtl/fsel_nib_alu.sv
module fsel_nib_alu #(
  parameter int NUM_NIB = 16,
  localparam int NIB_W = fsa_pkg::NIB_W,
  localparam int REG_W = NUM_NIB * NIB_W,
  localparam int IDX_W = $clog2(NUM_NIB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [3:0]       cmd_field,
  input  logic [IDX_W-1:0] cmd_p,
  input  logic             cmd_dec,
  input  logic [REG_W-1:0] opa,
  input  logic [REG_W-1:0] opb,
  output logic [REG_W-1:0] res_a,
  output logic [REG_W-1:0] res_b,
  output logic             carry,
  output logic             done
);
  import fsa_pkg::*;

  logic             busy;
  logic [IDX_W-1:0] idx, hi_q;
  fsa_op_e          op_q;
  logic             dec_q, chain_q;
  logic [REG_W-1:0] ra, rb;

  logic [IDX_W-1:0] win_lo, win_hi;
  logic [NIB_W-1:0] xa, yb, y_in, dig_d, new_a, new_b;
  logic             dig_c;

  fsa_window #(.NUM_NIB(NUM_NIB)) u_window (
    .code(cmd_field), .ptr(cmd_p), .lo(win_lo), .hi(win_hi)
  );

  assign xa   = ra[int'(idx)*NIB_W +: NIB_W];
  assign yb   = rb[int'(idx)*NIB_W +: NIB_W];
  assign y_in = op_is_unary(op_q) ? '0 : yb;

  fsa_digit u_digit (
    .x(xa), .y(y_in), .cin(chain_q), .sub(op_is_sub(op_q)), .dec(dec_q),
    .d(dig_d), .cout(dig_c)
  );

  always_comb begin
    new_a = xa;
    new_b = yb;
    case (op_q)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: new_a = dig_d;
      OP_CLR:  new_a = '0;
      OP_COPY: new_a = yb;
      OP_EXCH: begin new_a = yb; new_b = xa; end
      default: ;
    endcase
  end

  assign cmd_ready = !busy;
  assign res_a     = ra;
  assign res_b     = rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      hi_q    <= '0;
      op_q    <= OP_PASS;
      dec_q   <= 1'b0;
      chain_q <= 1'b0;
      ra      <= '0;
      rb      <= '0;
      carry   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy    <= 1'b1;
          idx     <= win_lo;
          hi_q    <= win_hi;
          op_q    <= fsa_op_e'(cmd_op);
          dec_q   <= cmd_dec;
          chain_q <= op_is_unary(fsa_op_e'(cmd_op));
          ra      <= opa;
          rb      <= opb;
        end
      end else begin
        ra[int'(idx)*NIB_W +: NIB_W] <= new_a;
        rb[int'(idx)*NIB_W +: NIB_W] <= new_b;
        chain_q <= dig_c;
        if (idx == hi_q) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (op_is_arith(op_q)) carry <= dig_c;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R2: done only follows a busy cycle and lasts one cycle
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: the walking index never leaves the window
  assert_idx_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= hi_q));
  // R9: data-movement operations leave the flag alone
  assert_carry_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_is_arith(op_q)) |-> $stable(carry));
  // R11: a command offered mid-operation does not alter the captured one
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && idx != hi_q) |=> (busy && $stable(op_q) && $stable(hi_q)));
  // R6: valid decimal digits always yield a valid decimal digit
  assert_dec_digit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dec_q && op_is_arith(op_q) && xa <= 4'd9 && y_in <= 4'd9) |-> (dig_d <= 4'd9));
endmodule

// File: tb/test_fsel_nib_alu.sv
module test_fsel_nib_alu;
  localparam int NN = 16;
  localparam int RW = NN * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [3:0]    cmd_field = '0;
  logic [3:0]    cmd_p = '0;
  logic          cmd_dec = 1'b0;
  logic [RW-1:0] opa = '0, opb = '0;
  logic [RW-1:0] res_a, res_b;
  logic          carry, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic exp_cy = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  fsel_nib_alu #(.NUM_NIB(NN)) i_fsel_nib_alu (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_field, .cmd_p, .cmd_dec,
    .opa, .opb, .res_a, .res_b, .carry, .done
  );

  function automatic logic [63:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 7;
    seed ^= seed << 17;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Window table from R3
  task automatic win(input int f, input int p, output int lo, output int hi);
    case (f)
      0: begin lo = p; hi = p; end
      1: begin lo = 0; hi = p; end
      2: begin lo = 2; hi = 2; end
      3: begin lo = 0; hi = 2; end
      4: begin lo = 15; hi = 15; end
      5: begin lo = 3; hi = 14; end
      6: begin lo = 0; hi = 1; end
      7: begin lo = 0; hi = 15; end
      15: begin lo = 0; hi = 4; end
      default: begin lo = 0; hi = 0; end
    endcase
  endtask

  task automatic run_op(input int op, input int f, input int p, input bit dec,
                        input logic [RW-1:0] a, input logic [RW-1:0] b);
    int lo, hi, cnt, x, y, s, dg;
    logic [RW-1:0] ea, eb;
    bit c;
    win(f, p, lo, hi);
    ea = a; eb = b;
    c = (op == 2 || op == 3);
    for (int n = lo; n <= hi; n++) begin
      x = int'(a[n*4 +: 4]);
      y = (op == 2 || op == 3) ? 0 : int'(b[n*4 +: 4]);
      dg = x;
      if (op <= 3) begin
        s = (op == 1 || op == 3) ? x - y - int'(c) : x + y + int'(c);
        if (!dec) begin dg = s & 15; c = (s < 0 || s > 15); end
        else if (!(op == 1 || op == 3)) begin dg = s % 10; c = (s >= 10); end
        else if (s < 0) begin dg = (s + 10) & 15; c = 1; end
        else if (s >= 10) begin dg = s - 10; c = 0; end
        else begin dg = s; c = 0; end
        ea[n*4 +: 4] = 4'(dg);
      end else if (op == 4) ea[n*4 +: 4] = 4'h0;
      else if (op == 5) ea[n*4 +: 4] = b[n*4 +: 4];
      else if (op == 6) begin ea[n*4 +: 4] = b[n*4 +: 4]; eb[n*4 +: 4] = a[n*4 +: 4]; end
    end
    if (op <= 3) exp_cy = c;
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R1 ready idle", 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_field = 4'(f); cmd_p = 4'(p);
    cmd_dec = dec; opa = a; opb = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready === 1'b0, "R1 ready low after accept", 64'(cmd_ready), 64'd0);
    cnt = 0;
    while (done !== 1'b1 && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == hi - lo + 1, "R2 latency", 64'(cnt), 64'(hi - lo + 1));
    chk(res_a === ea, "R4/R5/R6/R7/R9 res_a", res_a, ea);
    chk(res_b === eb, "R4/R9 res_b", res_b, eb);
    chk(carry === exp_cy, "R8/R9 carry", 64'(carry), 64'(exp_cy));
    @(negedge clk);
    chk(done === 1'b0, "R2 done pulse", 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [RW-1:0] a0, b0, bg;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(carry === 1'b0, "R10 reset carry", 64'(carry), 64'd0);
    chk(done === 1'b0, "R10 reset done", 64'(done), 64'd0);
    chk(res_a === '0 && res_b === '0, "R10 reset results", res_a, 64'd0);
    chk(cmd_ready === 1'b1, "R1 reset ready", 64'(cmd_ready), 64'd1);

    // Directed: R6 9+9 decimal on nibble 0, R7 decimal 0-1, R5 hex F+1
    run_op(0, 0, 0, 1'b1, 64'h9, 64'h9);
    chk(res_a[3:0] === 4'h8 && carry === 1'b1, "R6 9+9", {res_a[3:0], 3'b0, carry}, 64'h81);
    run_op(3, 0, 0, 1'b1, 64'h0, 64'h0);
    chk(res_a[3:0] === 4'h9 && carry === 1'b1, "R7 0-1", {res_a[3:0], 3'b0, carry}, 64'h91);
    run_op(2, 0, 0, 1'b0, 64'hF, 64'h0);
    chk(res_a[3:0] === 4'h0 && carry === 1'b1, "R5 F+1", {res_a[3:0], 3'b0, carry}, 64'h01);
    // R9 / R10: a clear keeps the carry set above
    run_op(4, 7, 0, 1'b0, rnd(), rnd());
    chk(carry === 1'b1, "R9 carry kept by clear", 64'(carry), 64'd1);

    // Exhaustive digit sweep on one nibble (field P, p=5): R5 R6 R7 R8
    bg = rnd();
    for (int dm = 0; dm < 2; dm++)
      for (int op = 0; op < 2; op++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++) begin
            a0 = bg; b0 = ~bg;
            a0[23:20] = 4'(x); b0[23:20] = 4'(y);
            run_op(op, 0, 5, dm[0], a0, b0);
          end

    // Every field code, several pointers, every operation: R3 R4 R9
    for (int f = 0; f < 16; f++)
      for (int pi = 0; pi < 3; pi++)
        for (int op = 0; op < 8; op++)
          for (int dm = 0; dm < 2; dm++)
            run_op(op, f, (pi == 0) ? 0 : (pi == 1) ? 3 : 15, dm[0], rnd(), rnd());

    // R11: offers during a long operation are not taken
    a0 = 64'h0123_4567_89AB_CDEF; b0 = 64'h1111_1111_1111_1111;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_field = 4'd7; cmd_dec = 1'b0; opa = a0; opb = b0;
    @(negedge clk);
    cmd_op = 3'd4; opa = '1; opb = '1;
    for (int k = 0; k < 3; k++) begin
      chk(cmd_ready === 1'b0, "R11 ready low while busy", 64'(cmd_ready), 64'd0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    cnt = 0;
    while (done !== 1'b1 && cnt < 40) begin @(negedge clk); cnt++; end
    chk(res_a === a0 + b0, "R11 first command result", res_a, a0 + b0);
    chk(res_b === b0, "R11 second operand kept", res_b, b0);
    @(negedge clk);
    chk(res_a === a0 + b0 && cmd_ready === 1'b1, "R11 no late start", res_a, a0 + b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule